// File: doc/BRIEF.md
# Serial Control and Status Port for a Six-Channel Load Driver

This block is the serial slave that a host uses to program a six-channel load-driver controller and to read back its status. Each transfer is a 16-bit frame framed by an active-low chip select. While the frame is open, the block takes a control word from the serial data input and, at the same time, sends out a status word on the serial data output. Both words go least-significant bit first. The control word reaches the parallel control register only when chip select is released. The register feeds the protection and drive logic, and the status word comes back from that logic.

The serial pins run asynchronously to the system clock. The block oversamples them through a synchronizer chain and finds the serial clock edges and chip-select edges in the system clock domain. The host samples the output on falling serial-clock edges. The block changes the output on rising edges. The data output has an enable, which the pad uses as its tri-state control, so that several devices can share one return line.

The control register has these fields:
- bit 0 requests a status clear;
- bits 1 to 6 switch the six output channels on;
- bit 13 turns open-load detection on when it is low;
- bit 14 picks the long or the short fault delay;
- bit 15 is the software run enable, where low means standby.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset, `ctrl_word` is 16'hE000 (bits 15, 14 and 13 high, all other bits low), `status_clr` is low and `sdo_oe` is low.
- R2: While `csn_pin` is low, `sdi_pin` is sampled on each falling edge of `sclk_pin`. The first bit sampled is bit 0 of the word. Within four clock cycles of `csn_pin` rising, `ctrl_word` shows the received word with bits 0 and 7 to 12 forced to zero.
- R3: While `csn_pin` is high, edges on `sclk_pin` and values on `sdi_pin` change neither `ctrl_word`, `status_clr` nor the bit position of the next frame.
- R4: `sdo_oe` is high while `csn_pin` is low and low while it is high, each time after a synchronizer delay of at most three clock cycles.
- R5: `status_word` is captured on the falling edge of `csn_pin`. `sdo_pin` shows captured bit 0 before the first serial-clock edge. After the rising serial-clock edge that follows the k-th falling edge, it shows captured bit k. Changes on `status_word` during the frame have no effect.
- R6: A frame that has seen other than exactly 16 falling serial-clock edges when `csn_pin` rises is discarded, and `ctrl_word` keeps its value.
- R7: A committed frame with bit 0 high makes `status_clr` high for exactly one clock cycle. A discarded frame, or a frame with bit 0 low, makes no pulse.
- R8: A committed word with bit 15 low (standby) does not stop the serial port: later frames are received and committed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_pin | input | 1 | Chip select, active low |
| sclk_pin | input | 1 | Serial clock, idle low |
| sdi_pin | input | 1 | Serial data in, LSB first |
| status_word | input | 16 | Status word from the protection logic |
| sdo_pin | output | 1 | Serial data out, LSB first |
| sdo_oe | output | 1 | Output enable for the data-out pad |
| ctrl_word | output | 16 | Committed control register |
| status_clr | output | 1 | One-cycle status-clear pulse |

## Verification
The hardest case to reach is the frame whose length is wrong. Chip select must rise after 15, 17 or zero falling edges, and the bench must show that the register and the clear pulse stay untouched even when the discarded word carries the clear bit. The vector table mixes frames of these lengths with good 16-bit frames. Every frame also changes `status_word` in the middle of the transfer, so a late capture would show up on the returned bits. A directed burst of serial clocks while chip select is high then checks that the next frame still starts at bit 0.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int WORD_W = 16;
  localparam int CH_N   = 6;
  localparam int CFG_LO = WORD_W - 3;

  // Reset image: the three configuration bits high, all else low.
  function automatic logic [WORD_W-1:0] ctl_reset_value();
    logic [WORD_W-1:0] v;
    v = '0;
    for (int i = CFG_LO; i < WORD_W; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Bits that are stored: channel enables and configuration bits.
  function automatic logic [WORD_W-1:0] ctl_keep_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 1; i <= CH_N; i++) m[i] = 1'b1;
    for (int i = CFG_LO; i < WORD_W; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] ctl_clean(input logic [WORD_W-1:0] w);
    return w & ctl_keep_mask();
  endfunction
endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
  parameter int            N      = 3,
  parameter int            STAGES = 2,
  parameter logic [N-1:0]  IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] level
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= IDLE;
    end else begin
      stg[0] <= pins;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign level = stg[STAGES-1];
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] status_word,
  output logic              sdo_bit,
  output logic [WORD_W-1:0] rx_word,
  output logic              frame_ok
);
  localparam int               CNT_W    = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              take_bit, push_bit;

  assign take_bit = cs_active && sclk_fall;
  // The first rising edge comes before any sample and keeps bit 0 on the line.
  assign push_bit = cs_active && sclk_rise && (bit_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      tx_q    <= '0;
      bit_cnt <= '0;
    end else begin
      if (cs_fall) begin
        tx_q    <= status_word;
        bit_cnt <= '0;
      end else begin
        if (push_bit) tx_q <= {1'b0, tx_q[WORD_W-1:1]};
        if (take_bit) begin
          rx_q <= {sdi_s, rx_q[WORD_W-1:1]};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign sdo_bit  = tx_q[0];
  assign rx_word  = rx_q;
  assign frame_ok = cs_rise && (bit_cnt == CNT_FULL);

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_fall && !push_bit) |=> $stable(tx_q));
  a_r3_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_active && !cs_fall) |=> $stable(bit_cnt));
  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_MAX);
endmodule

// File: rtl/ser_ctl_reg.sv
module ser_ctl_reg
  import ser_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              clr_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= ctl_reset_value();
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= load && word[0];
      if (load) ctrl_q <= ctl_clean(word);
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ctrl_q));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~ctl_keep_mask()) == '0);
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_pin,
  input  logic              sclk_pin,
  input  logic              sdi_pin,
  input  logic [WORD_W-1:0] status_word,
  output logic              sdo_pin,
  output logic              sdo_oe,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              status_clr
);
  logic [2:0]        lvl;
  logic [1:0]        prev_q;
  logic              cs_active, cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic              sdo_bit, frame_ok;
  logic [WORD_W-1:0] rx_word;

  // Pin order: {sdi, sclk, csn}; chip select idles high.
  ser_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .IDLE(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins({sdi_pin, sclk_pin, csn_pin}),
    .level(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b01;
    else        prev_q <= lvl[1:0];
  end

  assign cs_active = ~lvl[0];
  assign cs_fall   =  prev_q[0] & ~lvl[0];
  assign cs_rise   = ~prev_q[0] &  lvl[0];
  assign sclk_rise = ~prev_q[1] &  lvl[1];
  assign sclk_fall =  prev_q[1] & ~lvl[1];

  ser_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_active(cs_active), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(lvl[2]),
    .status_word(status_word),
    .sdo_bit(sdo_bit), .rx_word(rx_word), .frame_ok(frame_ok)
  );

  ser_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n),
    .load(frame_ok), .word(rx_word),
    .ctrl_q(ctrl_word), .clr_pulse(status_clr)
  );

  assign sdo_oe  = cs_active;
  assign sdo_pin = cs_active ? sdo_bit : 1'b0;

  a_r7_pulse_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |-> $past(frame_ok));
  a_r3_no_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_active && !cs_rise) |=> $stable(ctrl_word));
endmodule

// File: tb/ser_ctl_port_bench.sv
module ser_ctl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam logic [15:0] KEEP = 16'hE07E;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] status_word = '0;
  logic        sdo, sdo_oe, status_clr;
  logic [15:0] ctrl_word;

  int checks = 0, fails = 0, clr_cycles = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_ctl_port u_ser_ctl_port (
    .clk(clk), .rst_n(rst_n), .csn_pin(csn), .sclk_pin(sclk), .sdi_pin(sdi),
    .status_word(status_word), .sdo_pin(sdo), .sdo_oe(sdo_oe),
    .ctrl_word(ctrl_word), .status_clr(status_clr)
  );

  always @(posedge clk) begin
    if (status_clr === 1'b1) clr_cycles++;
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Vector: {word[15:0], status[15:0], falling edges[4:0]}
  localparam logic [36:0] VEC [0:7] = '{
    {16'h807E, 16'hA5C3, 5'd16},
    {16'h0001, 16'h8001, 5'd16},
    {16'h1235, 16'hFFFF, 5'd15},
    {16'h7F81, 16'h0000, 5'd17},
    {16'hFFFF, 16'h5AA5, 5'd16},
    {16'h4000, 16'h1248, 5'd16},
    {16'h2055, 16'hE001, 5'd0},
    {16'hA02B, 16'h7FFE, 5'd16}
  };

  task automatic settle(input int n = SETTLE);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One frame of n falling edges; status changes mid-frame must not show.
  task automatic frame(input logic [15:0] w, input logic [15:0] st, input int n);
    logic [15:0] got, mask;
    got = '0; mask = '0;
    status_word = st;
    csn = 1'b0;
    settle();
    chk(sdo_oe === 1'b1, "R4 oe during frame", {31'd0, sdo_oe}, 1);
    chk(sdo === st[0], "R5 bit0 before clock", {31'd0, sdo}, {31'd0, st[0]});
    status_word = ~st;
    for (int i = 0; i < n; i++) begin
      sdi  = w[i % 16];
      sclk = 1'b1;
      settle();
      if (i < 16) begin got[i] = sdo; mask[i] = 1'b1; end
      sclk = 1'b0;
      settle();
    end
    csn = 1'b1;
    settle(SETTLE + 2);
    if (n > 0)
      chk((got & mask) === (st & mask), "R5 returned status", {16'd0, got & mask}, {16'd0, st & mask});
    chk(sdo_oe === 1'b0, "R4 oe after frame", {31'd0, sdo_oe}, 0);
  endtask

  initial begin
    logic [15:0] exp_ctrl;
    int          exp_clr;
    exp_ctrl = 16'hE000;
    exp_clr  = 0;
    settle(3);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk(ctrl_word === 16'hE000, "R1 ctrl reset", {16'd0, ctrl_word}, 32'hE000);
    chk(status_clr === 1'b0, "R1 clr reset", {31'd0, status_clr}, 0);
    chk(sdo_oe === 1'b0, "R1 oe reset", {31'd0, sdo_oe}, 0);

    // Table walk: R2 commit, R6 discard, R7 pulse
    for (int v = 0; v < 8; v++) begin
      logic [15:0] w, st;
      int n;
      w  = VEC[v][36:21];
      st = VEC[v][20:5];
      n  = int'(VEC[v][4:0]);
      if (n == 16) begin
        exp_ctrl = w & KEEP;
        if (w[0]) exp_clr++;
      end
      frame(w, st, n);
      chk(ctrl_word === exp_ctrl, (n == 16) ? "R2 commit" : "R6 discard",
          {16'd0, ctrl_word}, {16'd0, exp_ctrl});
      chk(clr_cycles == exp_clr, "R7 clear pulse count", clr_cycles, exp_clr);
    end

    // R3: serial clocks and data while chip select is high
    for (int i = 0; i < 20; i++) begin
      sdi = 1'b1; sclk = 1'b1; settle(); sclk = 1'b0; settle();
    end
    chk(ctrl_word === exp_ctrl, "R3 idle clocks ignored", {16'd0, ctrl_word}, {16'd0, exp_ctrl});
    chk(clr_cycles == exp_clr, "R3 no pulse when idle", clr_cycles, exp_clr);
    frame(16'h6003, 16'h0F0F, 16);
    exp_ctrl = 16'h6002; exp_clr++;
    chk(ctrl_word === exp_ctrl, "R3 next frame aligned", {16'd0, ctrl_word}, {16'd0, exp_ctrl});
    chk(clr_cycles == exp_clr, "R7 pulse after idle clocks", clr_cycles, exp_clr);

    // R8: standby word, then the port still accepts frames
    frame(16'h0000, 16'h3C3C, 16);
    chk(ctrl_word === 16'h0000, "R8 standby committed", {16'd0, ctrl_word}, 0);
    frame(16'hC0F0, 16'hC3C3, 16);
    chk(ctrl_word === 16'hC070, "R8 frame after standby", {16'd0, ctrl_word}, 32'hC070);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule